// File: doc/BRIEF.md
# Configurable Registered Address Buffer

This block is a single clocked register stage on the command and address path of a memory module. Each rising clock edge captures the incoming address lanes and the clock-enable, termination and chip-select lines, then drives them back out registered. Two static mode inputs set the shape of the data path. In wide mode the stage passes 25 lanes straight through. In split mode it registers 14 lanes and drives every registered bit onto two output copies, A and B, so one input bit can feed two loads. A second mode input picks which 14 input lanes are used in split mode.

The data outputs are gated by two active-low chip-select inputs. When both are inactive (high), the data register keeps its last value. When either is active, the register captures as usual. The clock-enable, termination and chip-select outputs always follow their inputs and ignore this gating. An active-low reset forces every output low at once, without a clock edge. It also clears every register. Release is passed through a two-flop synchroniser, so the outputs stay low for a short settling window after reset is released.

Top module: `addr_reg_buf`

## Requirements
- R1: While `rst_n` is low, every output is 0 and stays 0 on every clock edge.
- R2: Wide mode (`mode_split`=0 at reset): on each edge where an update is allowed, `q_a[24:0]` takes `d_in[24:0]` bit for bit. The value appears one edge after capture.
- R3: Split mode with `lane_hi`=0: `d_in[13:0]` is registered and driven on both `q_a[13:0]` and `q_b[13:0]`, and `q_a[24:14]` is 0.
- R4: Split mode with `lane_hi`=1: `d_in[24:11]` is registered and driven on both `q_a[13:0]` and `q_b[13:0]`, and `q_a[24:14]` is 0.
- R5: When `cs_n_a`=1 and `cs_n_b`=1 at a capture edge, `q_a` and `q_b` keep their values. If either input is 0, they update.
- R6: `cke_q_a`, `odt_q_a` and `cs_q_a` take `cke_in`, `odt_in` and `cs_n_a` one edge later, whatever the chip-select gating is doing. In split mode the `_b` copies equal the `_a` copies.
- R7: In wide mode, `q_b`, `cke_q_b`, `odt_q_b` and `cs_q_b` are held at 0.
- R8: Driving `rst_n` low forces all outputs to 0 at once, with no clock edge needed, even while chip-select gating is holding the data.
- R9: After `rst_n` rises, the first two rising edges leave all outputs at 0. The first capture happens on the third rising edge.
- R10: `mode_split` and `lane_hi` are sampled only during reset and the two-edge settling window. Changing them during normal operation has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Active-low reset; forces all outputs low |
| mode_split | input | 1 | 0 = 25-lane wide mode, 1 = 14-lane split mode |
| lane_hi | input | 1 | Split mode: 0 = lower lanes, 1 = upper lanes |
| cs_n_a | input | 1 | Primary chip select, active low; also registered out |
| cs_n_b | input | 1 | Secondary chip select, active low; gating only |
| cke_in | input | 1 | Clock-enable line |
| odt_in | input | 1 | Termination control line |
| d_in | input | 25 | Address and command lanes |
| cke_q_a | output | 1 | Registered clock enable, copy A |
| cke_q_b | output | 1 | Registered clock enable, copy B |
| odt_q_a | output | 1 | Registered termination, copy A |
| odt_q_b | output | 1 | Registered termination, copy B |
| cs_q_a | output | 1 | Registered chip select, copy A |
| cs_q_b | output | 1 | Registered chip select, copy B |
| q_a | output | 25 | Registered data, copy A |
| q_b | output | 14 | Registered data, copy B (split mode only) |

## Verification
Two functions can act in the same cycle: reset forcing the outputs low, and chip-select gating holding the data register. The bench provokes this by holding both chip selects high after loading a nonzero word, then dropping `rst_n` halfway through a clock period. It checks one time step later, before any edge, that every output is already 0. A separate case keeps the gating active while the control lines toggle, to confirm that the two paths stay apart.

// File: rtl/addr_reg_buf_pkg.sv
// Package: shared widths and the latched configuration type for the
// registered address buffer. Assumes the narrow path fits inside the wide one.
package addr_reg_buf_pkg;
    localparam int unsigned WIDE_LANES   = 25;
    localparam int unsigned NARROW_LANES = 14;

    typedef struct packed {
        logic split;    // 1 = one-to-two fan-out
        logic lane_hi;  // split mode: take upper lanes
    } buf_cfg_t;
endpackage

// File: rtl/arb_rst_sync.sv
// Reset release synchroniser. Asserts its output together with rst_n and
// raises it only after STAGES rising edges. Assumes STAGES >= 2.
module arb_rst_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic ready
);
    logic [STAGES-1:0] shift_q;

    // Shift ones in after release; clear at once on assertion.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shift_q <= '0;
        else        shift_q <= {shift_q[STAGES-2:0], 1'b1};
    end

    assign ready = shift_q[STAGES-1];
endmodule

// File: rtl/arb_lane_pick.sv
// Input lane selector. Wide mode passes every lane. Split mode packs the
// chosen NARROW window into the low bits and zeroes the rest.
// Assumes NARROW <= WIDE.
module arb_lane_pick #(
    parameter int unsigned WIDE   = 25,
    parameter int unsigned NARROW = 14
) (
    input  logic              split,
    input  logic              lane_hi,
    input  logic [WIDE-1:0]   d_in,
    output logic [WIDE-1:0]   d_sel
);
    localparam int unsigned HI_BASE = WIDE - NARROW;

    // Choose the lane window for the current configuration.
    always_comb begin
        d_sel = '0;
        if (!split)       d_sel = d_in;
        else if (lane_hi) d_sel[NARROW-1:0] = d_in[HI_BASE +: NARROW];
        else              d_sel[NARROW-1:0] = d_in[NARROW-1:0];
    end
endmodule

// File: rtl/arb_cap_reg.sv
// Capture register with hold. A synchronous active-low clear (srst_n)
// empties it; otherwise it loads d on every edge unless hold is high.
module arb_cap_reg #(
    parameter int unsigned W = 25
) (
    input  logic         clk,
    input  logic         srst_n,
    input  logic         hold,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Clear, hold, or load on each rising edge.
    always_ff @(posedge clk) begin
        if (!srst_n)   q <= '0;
        else if (!hold) q <= d;
    end

    // R5
    property hold_keeps_p;
        @(posedge clk) disable iff (!srst_n) hold |=> $stable(q);
    endproperty
    hold_keeps_chk: assert property (hold_keeps_p);
endmodule

// File: rtl/addr_reg_buf.sv
// Top of the configurable registered address buffer. It latches the mode
// inputs while the reset is settling, registers the control lines with no
// gating, registers the selected data lanes under dual chip-select hold, and
// forces every output to zero combinationally while rst_n is low.
// Assumes mode inputs are stable across reset release.
module addr_reg_buf
    import addr_reg_buf_pkg::*;
#(
    parameter int unsigned WIDE       = WIDE_LANES,
    parameter int unsigned NARROW     = NARROW_LANES,
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_split,
    input  logic              lane_hi,
    input  logic              cs_n_a,
    input  logic              cs_n_b,
    input  logic              cke_in,
    input  logic              odt_in,
    input  logic [WIDE-1:0]   d_in,
    output logic              cke_q_a,
    output logic              cke_q_b,
    output logic              odt_q_a,
    output logic              odt_q_b,
    output logic              cs_q_a,
    output logic              cs_q_b,
    output logic [WIDE-1:0]   q_a,
    output logic [NARROW-1:0] q_b
);
    localparam int unsigned CTL_W = 3;

    logic              ready;
    buf_cfg_t          cfg_q;
    logic [WIDE-1:0]   d_sel;
    logic [WIDE-1:0]   data_q;
    logic [CTL_W-1:0]  ctl_q;
    logic              gate_hold;

    arb_rst_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .ready (ready)
    );

    // Sample the mode pins only until the reset has settled.
    always_ff @(posedge clk) begin
        if (!ready) cfg_q <= '{split: mode_split, lane_hi: lane_hi};
    end

    arb_lane_pick #(.WIDE(WIDE), .NARROW(NARROW)) u_pick (
        .split   (cfg_q.split),
        .lane_hi (cfg_q.lane_hi),
        .d_in    (d_in),
        .d_sel   (d_sel)
    );

    // Data holds only when both chip selects are inactive.
    assign gate_hold = cs_n_a & cs_n_b;

    arb_cap_reg #(.W(WIDE)) u_data (
        .clk    (clk),
        .srst_n (ready),
        .hold   (gate_hold),
        .d      (d_sel),
        .q      (data_q)
    );

    arb_cap_reg #(.W(CTL_W)) u_ctl (
        .clk    (clk),
        .srst_n (ready),
        .hold   (1'b0),
        .d      ({cke_in, odt_in, cs_n_a}),
        .q      (ctl_q)
    );

    // Drive the A and B copies, masked to zero while rst_n is low.
    always_comb begin
        q_a     = data_q & {WIDE{rst_n}};
        cke_q_a = ctl_q[2] & rst_n;
        odt_q_a = ctl_q[1] & rst_n;
        cs_q_a  = ctl_q[0] & rst_n;
        if (cfg_q.split) begin
            q_b     = data_q[NARROW-1:0] & {NARROW{rst_n}};
            cke_q_b = cke_q_a;
            odt_q_b = odt_q_a;
            cs_q_b  = cs_q_a;
        end else begin
            q_b     = '0;
            cke_q_b = 1'b0;
            odt_q_b = 1'b0;
            cs_q_b  = 1'b0;
        end
    end

    // Output-level checks on reset, disabled copies and fan-out.
    always_comb begin
        // R1
        if (!rst_n) rst_low_chk: assert (q_a == '0 && q_b == '0 && !cke_q_a && !cs_q_a);
        // R7
        if (!cfg_q.split) b_off_chk: assert (q_b == '0 && !cke_q_b && !odt_q_b && !cs_q_b);
        // R3
        if (cfg_q.split) fanout_chk: assert (q_b == q_a[NARROW-1:0]);
    end

    // R6
    property ctl_follow_p;
        @(posedge clk) disable iff (!rst_n)
            ready |=> (ctl_q == $past({cke_in, odt_in, cs_n_a}));
    endproperty
    ctl_follow_chk: assert property (ctl_follow_p);

    // R10
    property cfg_static_p;
        @(posedge clk) disable iff (!rst_n) ready |=> $stable(cfg_q);
    endproperty
    cfg_static_chk: assert property (cfg_static_p);

    // R9
    property settle_low_p;
        @(posedge clk) disable iff (!rst_n) !ready |=> (ctl_q == '0 || ready);
    endproperty
    settle_low_chk: assert property (settle_low_p);
endmodule

// File: tb/sim_addr_reg_buf.sv
module sim_addr_reg_buf;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_split = 1'b0, lane_hi = 1'b0;
    logic        cs_n_a = 1'b1, cs_n_b = 1'b1;
    logic        cke_in = 1'b0, odt_in = 1'b0;
    logic [24:0] d_in = '0;
    logic        cke_q_a, cke_q_b, odt_q_a, odt_q_b, cs_q_a, cs_q_b;
    logic [24:0] q_a;
    logic [13:0] q_b;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    addr_reg_buf u0 (
        .clk(clk), .rst_n(rst_n), .mode_split(mode_split), .lane_hi(lane_hi),
        .cs_n_a(cs_n_a), .cs_n_b(cs_n_b), .cke_in(cke_in), .odt_in(odt_in),
        .d_in(d_in), .cke_q_a(cke_q_a), .cke_q_b(cke_q_b), .odt_q_a(odt_q_a),
        .odt_q_b(odt_q_b), .cs_q_a(cs_q_a), .cs_q_b(cs_q_b), .q_a(q_a), .q_b(q_b)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s got=%h exp=%h", req, what, got, exp);
        end
    endtask

    function automatic logic [24:0] exp_a(input logic sp, input logic hi, input logic [24:0] d);
        if (!sp) return d;
        return hi ? {11'b0, d[24:11]} : {11'b0, d[13:0]};
    endfunction

    function automatic logic [13:0] exp_b(input logic sp, input logic hi, input logic [24:0] d);
        if (!sp) return '0;
        return hi ? d[24:11] : d[13:0];
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic [24:0] d, input logic ca, input logic cb,
                         input logic ck, input logic od);
        d_in = d; cs_n_a = ca; cs_n_b = cb; cke_in = ck; odt_in = od;
    endtask

    // Reset with a chosen mode, check the settling window (R1, R9).
    task automatic t_reset(input logic sp, input logic hi);
        @(negedge clk);
        rst_n = 1'b0; mode_split = sp; lane_hi = hi;
        drive(25'h1FFFFFF, 1'b0, 1'b0, 1'b1, 1'b1);
        repeat (3) tick();
        chk("R1", "q_a in reset", {7'b0, q_a}, 32'h0);
        chk("R1", "ctl in reset", {26'b0, cke_q_a, cke_q_b, odt_q_a, odt_q_b, cs_q_a, cs_q_b}, 32'h0);
        rst_n = 1'b1;
        drive(25'h1ABCDEF, 1'b0, 1'b0, 1'b1, 1'b1);
        tick();
        chk("R9", "q_a after edge 1", {7'b0, q_a}, 32'h0);
        tick();
        chk("R9", "q_a after edge 2", {7'b0, q_a}, 32'h0);
        chk("R9", "cke after edge 2", {31'b0, cke_q_a}, 32'h0);
        tick();
        chk("R9", "q_a after edge 3", {7'b0, q_a}, {7'b0, exp_a(sp, hi, 25'h1ABCDEF)});
    endtask

    // Apply data with chip select active and compare both copies.
    task automatic t_pass(input string req, input logic sp, input logic hi, input logic [24:0] d);
        drive(d, 1'b0, 1'b1, 1'b0, 1'b1);
        tick();
        chk(req, "q_a", {7'b0, q_a}, {7'b0, exp_a(sp, hi, d)});
        chk(req, "q_b", {18'b0, q_b}, {18'b0, exp_b(sp, hi, d)});
    endtask

    // Hold gating and ungated control lines (R5, R6).
    task automatic t_hold();
        logic [24:0] kept;
        drive(25'h0123456, 1'b1, 1'b0, 1'b0, 1'b0);
        tick();
        chk("R5", "update with cs_n_b low", {7'b0, q_a}, 32'h0123456);
        kept = q_a;
        drive(25'h1555555, 1'b1, 1'b1, 1'b1, 1'b0);
        tick();
        chk("R5", "held data", {7'b0, q_a}, {7'b0, kept});
        chk("R6", "cke under hold", {31'b0, cke_q_a}, 32'h1);
        chk("R6", "cs copy under hold", {31'b0, cs_q_a}, 32'h1);
        drive(25'h0AAAAAA, 1'b1, 1'b1, 1'b0, 1'b1);
        tick();
        chk("R5", "still held", {7'b0, q_a}, {7'b0, kept});
        chk("R6", "odt under hold", {30'b0, odt_q_a, cke_q_a}, 32'h2);
        drive(25'h0AAAAAA, 1'b0, 1'b1, 1'b0, 1'b1);
        tick();
        chk("R5", "update with cs_n_a low", {7'b0, q_a}, 32'h0AAAAAA);
        chk("R6", "cs follows", {31'b0, cs_q_a}, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // Wide mode
        t_reset(1'b0, 1'b0);
        t_pass("R2", 1'b0, 1'b0, 25'h1000001);
        t_pass("R2", 1'b0, 1'b0, 25'h0F0F0F0);
        drive(25'h1FFFFFF, 1'b0, 1'b0, 1'b1, 1'b1);
        tick();
        chk("R7", "b copies off", {14'b0, q_b, cke_q_b, odt_q_b, cs_q_b, 1'b0}, 32'h0);
        t_hold();

        // R10: mode pins change during operation, no effect
        mode_split = 1'b1; lane_hi = 1'b1;
        t_pass("R10", 1'b0, 1'b0, 25'h1234567);

        // R8: reset lands while gating holds the data
        drive(25'h1FEDCBA, 1'b0, 1'b0, 1'b1, 1'b1);
        tick();
        drive(25'h0000000, 1'b1, 1'b1, 1'b1, 1'b1);
        tick();
        chk("R8", "held before reset", {7'b0, q_a}, 32'h1FEDCBA);
        #2 rst_n = 1'b0;
        #1;
        chk("R8", "q_a forced low", {7'b0, q_a}, 32'h0);
        chk("R8", "ctl forced low", {29'b0, cke_q_a, odt_q_a, cs_q_a}, 32'h0);

        // Split mode, lower lanes
        t_reset(1'b1, 1'b0);
        t_pass("R3", 1'b1, 1'b0, 25'h1FFC001);
        t_pass("R3", 1'b1, 1'b0, 25'h0002ABC);
        drive(25'h0, 1'b0, 1'b0, 1'b1, 1'b0);
        tick();
        chk("R6", "cke b copy", {30'b0, cke_q_a, cke_q_b}, 32'h3);

        // Split mode, upper lanes
        t_reset(1'b1, 1'b1);
        t_pass("R4", 1'b1, 1'b1, 25'h1FFC001);
        t_pass("R4", 1'b1, 1'b1, 25'h0803000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule